// File: doc/BRIEF.md
# Configuration Cycle Type 1 to Type 0 Translator

This block sits in the downstream path of a bus bridge. It looks at the address phase of a configuration transaction that arrives on the primary side. It decides whether the bridge claims that transaction and reissues it as a Type 0 configuration cycle to a device on the secondary bus.

When the cycle is claimed, the block builds the secondary address. It forces the type bits to zero and keeps the function and register fields. It also places a one-hot device-select line on the upper address half. The device-number field is either cleared or passed through, depending on whether the secondary bus runs conventional PCI or PCI-X. An access aimed at the broadcast device number 31 may be flagged as a special cycle instead.

Inputs are taken when `in_valid_i` is high. The decision and the rewritten address appear one clock later, qualified by `out_valid_o`.

Top module: `cfg_t1t0_xlate`

## Requirements
- R1: `claim_o` is high only if primary address bits [1:0] were 2'b01 (the Type 1 marker).
- R2: `claim_o` is high only if primary address bits [23:16] equal `sec_bus_i`.
- R3: `claim_o` is high only if the command is 4'b1010 (configuration read) or 4'b1011 (configuration write). Any other command gives `claim_o` low.
- R4: Outputs are registered. Inputs sampled with `in_valid_i` high appear on the next clock with `out_valid_o` high. While `out_valid_o` is low, `claim_o` and `special_o` are low. Reset clears all outputs to zero.
- R5: `sec_addr_o[1:0]` is always 2'b00 when `out_valid_o` is high.
- R6: For device number d = primary bits [15:11] with d < 16, `sec_addr_o[31:16]` has exactly bit 16+d set.
- R7: For device numbers 16 to 31, `sec_addr_o[31:16]` is zero.
- R8: `sec_addr_o[15:11]` is zero when `pcix_mode_i` = 0 (conventional PCI). It equals the device number when `pcix_mode_i` = 1 (PCI-X).
- R9: `sec_addr_o[10:2]` (function [10:8] and register [7:2]) equal the primary bits [10:2].
- R10: `special_o` is high only for a claimed configuration write with device 31, function 7 and register 0. Any other claimed device-31 access keeps `claim_o` high and `special_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Address phase present on the inputs |
| pri_addr_i | input | 32 | Primary address phase |
| cmd_i | input | 4 | Primary bus command |
| sec_bus_i | input | 8 | Secondary bus number register value |
| pcix_mode_i | input | 1 | 1 = secondary bus in PCI-X mode, 0 = conventional PCI |
| out_valid_o | output | 1 | Registered outputs are valid |
| claim_o | output | 1 | Translate to Type 0 |
| sec_addr_o | output | 32 | Rewritten secondary address |
| special_o | output | 1 | Convert to special cycle |

## Verification
The bench sweeps every device number in both bus modes, because an off-by-one in the select decode would light the wrong line or a line for devices 16 and up. It also drives near-miss claim conditions one at a time: type bits 00/10/11, a bus number one away from the register, and commands adjacent to 1010b/1011b. A design with a loose compare would then claim foreign cycles. Device-31 accesses with each special-cycle qualifier broken in turn expose a special flag that is decoded too widely. Gaps in the valid strobe catch outputs that leak a decision without a valid.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned DEV_W     = 5;
  localparam int unsigned FUNC_W    = 3;
  localparam int unsigned REG_W     = 6;
  localparam int unsigned CMD_W     = 4;
  localparam int unsigned IDSEL_N   = 16;

  localparam logic [1:0]        TYPE1_CODE = 2'b01;
  localparam logic [CMD_W-1:0]  CMD_CFG_RD = 4'b1010;
  localparam logic [CMD_W-1:0]  CMD_CFG_WR = 4'b1011;
  localparam logic [DEV_W-1:0]  DEV_BCAST  = '1;
  localparam logic [FUNC_W-1:0] FUNC_SPEC  = '1;
  localparam logic [REG_W-1:0]  REG_SPEC   = '0;

  typedef struct packed {
    logic [BUS_W-1:0]  hi;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [REG_W-1:0]  regn;
    logic [1:0]        typ;
  } cfg_addr_t;
endpackage

// File: rtl/cfg_claim_dec.sv
module cfg_claim_dec
  import cfg_xlate_pkg::*;
(
  input  logic [1:0]        typ_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [BUS_W-1:0]  sec_bus_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [REG_W-1:0]  regn_i,
  output logic              claim_o,
  output logic              special_o
);
  logic is_cfg, is_wr, spec_tgt;

  assign is_cfg   = (cmd_i == CMD_CFG_RD) || (cmd_i == CMD_CFG_WR);
  assign is_wr    = (cmd_i == CMD_CFG_WR);
  assign claim_o  = (typ_i == TYPE1_CODE) && (bus_i == sec_bus_i) && is_cfg;
  // broadcast device, top function, register 0, write only
  assign spec_tgt = (dev_i == DEV_BCAST) && (func_i == FUNC_SPEC) && (regn_i == REG_SPEC);
  assign special_o = claim_o && is_wr && spec_tgt;
endmodule

// File: rtl/cfg_idsel_gen.sv
module cfg_idsel_gen
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned N = IDSEL_N
) (
  input  logic [DEV_W-1:0] dev_i,
  output logic [N-1:0]     idsel_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign idsel_o[i] = (dev_i == DEV_W'(i));
  end
endmodule

// File: rtl/cfg_addr_rewrite.sv
module cfg_addr_rewrite
  import cfg_xlate_pkg::*;
(
  input  logic [IDSEL_N-1:0] idsel_i,
  input  logic [DEV_W-1:0]   dev_i,
  input  logic [FUNC_W-1:0]  func_i,
  input  logic [REG_W-1:0]   regn_i,
  input  logic               pcix_mode_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [DEV_W-1:0] dev_out;

  assign dev_out = pcix_mode_i ? dev_i : '0;
  assign addr_o  = {idsel_i, dev_out, func_i, regn_i, 2'b00};
endmodule

// File: rtl/cfg_t1t0_xlate.sv
module cfg_t1t0_xlate
  import cfg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] pri_addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [BUS_W-1:0]  sec_bus_i,
  input  logic              pcix_mode_i,
  output logic              out_valid_o,
  output logic              claim_o,
  output logic [ADDR_W-1:0] sec_addr_o,
  output logic              special_o
);
  cfg_addr_t           pa;
  logic                claim_d, special_d;
  logic [IDSEL_N-1:0]  idsel;
  logic [ADDR_W-1:0]   addr_d;
  logic                unused_hi;

  assign pa        = cfg_addr_t'(pri_addr_i);
  assign unused_hi = ^pa.hi;

  cfg_claim_dec u_dec (
    .typ_i     (pa.typ),
    .bus_i     (pa.bus),
    .sec_bus_i (sec_bus_i),
    .cmd_i     (cmd_i),
    .dev_i     (pa.dev),
    .func_i    (pa.func),
    .regn_i    (pa.regn),
    .claim_o   (claim_d),
    .special_o (special_d)
  );

  cfg_idsel_gen #(.N(IDSEL_N)) u_idsel (
    .dev_i   (pa.dev),
    .idsel_o (idsel)
  );

  cfg_addr_rewrite u_rw (
    .idsel_i     (idsel),
    .dev_i       (pa.dev),
    .func_i      (pa.func),
    .regn_i      (pa.regn),
    .pcix_mode_i (pcix_mode_i),
    .addr_o      (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      claim_o     <= 1'b0;
      special_o   <= 1'b0;
      sec_addr_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      claim_o     <= in_valid_i && claim_d;
      special_o   <= in_valid_i && special_d;
      if (in_valid_i) sec_addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/cfg_t1t0_xlate_chk.sv
module cfg_t1t0_xlate_chk
  import cfg_xlate_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [ADDR_W-1:0] pri_addr_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic [BUS_W-1:0]  sec_bus_i,
  input logic              pcix_mode_i,
  input logic              out_valid_o,
  input logic              claim_o,
  input logic [ADDR_W-1:0] sec_addr_o,
  input logic              special_o
);
  a_r1_type1_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> $past(pri_addr_i[1:0]) == 2'b01);
  a_r2_bus_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> $past(pri_addr_i[23:16]) == $past(sec_bus_i));
  a_r3_cfg_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> ($past(cmd_i) == CMD_CFG_RD || $past(cmd_i) == CMD_CFG_WR));
  a_r4_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r4_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !claim_o && !special_o);
  a_r5_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> sec_addr_o[1:0] == 2'b00);
  a_r6_onehot_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $onehot0(sec_addr_o[31:16]));
  a_r7_high_dev_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(pri_addr_i[15]) |-> sec_addr_o[31:16] == '0);
  a_r9_fields_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> sec_addr_o[10:2] == $past(pri_addr_i[10:2]));
  a_r10_special_claimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    special_o |-> claim_o && $past(cmd_i) == CMD_CFG_WR);
endmodule

bind cfg_t1t0_xlate cfg_t1t0_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .pri_addr_i  (pri_addr_i),
  .cmd_i       (cmd_i),
  .sec_bus_i   (sec_bus_i),
  .pcix_mode_i (pcix_mode_i),
  .out_valid_o (out_valid_o),
  .claim_o     (claim_o),
  .sec_addr_o  (sec_addr_o),
  .special_o   (special_o)
);

// File: tb/cfg_t1t0_xlate_bench.sv
module cfg_t1t0_xlate_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] pri_addr_i = '0;
  logic [3:0]  cmd_i = '0;
  logic [7:0]  sec_bus_i = '0;
  logic        pcix_mode_i = 1'b0;
  logic        out_valid_o, claim_o, special_o;
  logic [31:0] sec_addr_o;

  int compared = 0;
  int mismatched = 0;

  // expected state of the outputs after the next edge
  logic        e_v = 0, e_claim = 0, e_spec = 0;
  logic [31:0] e_addr = '0;
  string       e_tag = "R4";

  always #4 clk_i = ~clk_i;

  cfg_t1t0_xlate u_cfg_t1t0_xlate (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic v, input logic [31:0] a, input logic [3:0] c,
                       input logic [7:0] b, input logic px);
    int dev;
    logic cl, is_cfg;
    logic [31:0] r;
    dev    = int'(a[15:11]);
    is_cfg = (c == 4'hA) || (c == 4'hB);
    cl     = (a[1:0] == 2'b01) && (a[23:16] == b) && is_cfg;
    e_v    = v;
    e_claim = v && cl;
    e_spec  = v && cl && (c == 4'hB) && (dev == 31) && (a[10:8] == 3'd7) && (a[7:2] == 6'd0);
    if (v) begin
      r = '0;
      if (dev < 16) r[16+dev] = 1'b1;
      if (px) r[15:11] = a[15:11];
      r[10:2] = a[10:2];
      e_addr = r;
    end
  endtask

  task automatic compare_now();
    chk({"R4 valid ", e_tag}, {31'd0, out_valid_o}, {31'd0, e_v});
    chk({"R1 R2 R3 claim ", e_tag}, {31'd0, claim_o}, {31'd0, e_claim});
    chk({"R10 special ", e_tag}, {31'd0, special_o}, {31'd0, e_spec});
    if (e_v) chk({"R5 R6 R7 R8 R9 addr ", e_tag}, sec_addr_o, e_addr);
  endtask

  // compare previous cycle's result, then drive a new address phase
  task automatic step(input string tag, input logic v, input logic [31:0] a,
                      input logic [3:0] c, input logic [7:0] b, input logic px);
    @(negedge clk_i);
    compare_now();
    in_valid_i = v; pri_addr_i = a; cmd_i = c; sec_bus_i = b; pcix_mode_i = px;
    model(v, a, c, b, px);
    e_tag = tag;
  endtask

  function automatic logic [31:0] mk(input logic [7:0] bus, input int dev, input int fn,
                                      input int rg, input logic [1:0] typ);
    return {8'h5A, bus, dev[4:0], fn[2:0], rg[5:0], typ};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state
    chk("R4 reset valid", {31'd0, out_valid_o}, 32'd0);
    chk("R4 reset addr", sec_addr_o, 32'd0);
    rst_ni = 1'b1;
    // R6 R7 R8: every device, both modes
    for (int px = 0; px < 2; px++)
      for (int d = 0; d < 32; d++)
        step("R6_R7_R8 sweep", 1'b1, mk(8'h12, d, d % 8, d * 2, 2'b01), 4'hA, 8'h12, px[0]);
    // R1 wrong type bits
    for (int t = 0; t < 4; t++)
      step("R1 type", 1'b1, mk(8'h07, 3, 1, 5, t[1:0]), 4'hB, 8'h07, 1'b0);
    // R2 bus mismatch by one either way
    step("R2 bus+1", 1'b1, mk(8'h08, 4, 0, 1, 2'b01), 4'hA, 8'h07, 1'b0);
    step("R2 bus-1", 1'b1, mk(8'h06, 4, 0, 1, 2'b01), 4'hA, 8'h07, 1'b0);
    // R3 all commands
    for (int c = 0; c < 16; c++)
      step("R3 cmd", 1'b1, mk(8'h33, 9, 2, 7, 2'b01), c[3:0], 8'h33, 1'b1);
    // R10 special cycle and each qualifier broken
    step("R10 special", 1'b1, mk(8'h01, 31, 7, 0, 2'b01), 4'hB, 8'h01, 1'b0);
    step("R10 read",    1'b1, mk(8'h01, 31, 7, 0, 2'b01), 4'hA, 8'h01, 1'b0);
    step("R10 func6",   1'b1, mk(8'h01, 31, 6, 0, 2'b01), 4'hB, 8'h01, 1'b0);
    step("R10 reg1",    1'b1, mk(8'h01, 31, 7, 1, 2'b01), 4'hB, 8'h01, 1'b1);
    step("R10 dev30",   1'b1, mk(8'h01, 30, 7, 0, 2'b01), 4'hB, 8'h01, 1'b0);
    step("R10 badbus",  1'b1, mk(8'h02, 31, 7, 0, 2'b01), 4'hB, 8'h01, 1'b0);
    // R4 gaps in valid with claimable inputs present
    step("R4 gap", 1'b0, mk(8'h01, 31, 7, 0, 2'b01), 4'hB, 8'h01, 1'b0);
    step("R4 gap", 1'b0, mk(8'h01, 2, 7, 0, 2'b01), 4'hA, 8'h01, 1'b0);
    step("R4 resume", 1'b1, mk(8'h01, 2, 7, 63, 2'b01), 4'hA, 8'h01, 1'b1);
    // R9 random mix
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      logic [7:0] b;
      a = $urandom;
      b = ($urandom % 2 == 0) ? a[23:16] : 8'($urandom);
      if ($urandom % 2 == 0) a[1:0] = 2'b01;
      step("R9 random", 1'($urandom % 4 != 0), a,
           ($urandom % 2 == 0) ? 4'($urandom % 2 + 10) : 4'($urandom), b, 1'($urandom));
    end
    step("R4 drain", 1'b0, '0, '0, '0, 1'b0);
    @(negedge clk_i);
    compare_now();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule